// File: doc/BRIEF.md
# BCD Calendar Clock With Calibration

This block keeps wall-clock time and a calendar for a larger chip. It is fed by a clock-enable that pulses once per cycle of a 32.768 kHz crystal. That rate is divided down to one update per second. The block counts seconds, minutes, hours, day of month, month, two-digit year and a free-running weekday, all in packed BCD. A signed rate trim corrects a crystal that runs fast or slow. It does this by inserting or swallowing individual oscillator ticks at evenly spaced points inside a long correction window.

Software reaches the block through a simple register port. One register bank serves both directions. A rising edge on the snapshot control bit copies the running counters into the bank so that a multi-byte read is coherent. While the hold control bit is set, the counters stand still and software may fill the bank. Clearing hold loads the bank into the counters and restarts the sub-second divider. A calibration mode drives a nominal 512 Hz square wave that is taken from the untrimmed tick stream, so its frequency can be measured against a reference.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the bank reads seconds 00, minutes 00, hours 00, date 01, month 01, year 00 and weekday 1. Registers 0 and 1 read 00, and `cal_out` is 0.
- R2: With trim zero, seconds advance exactly once per TICK_HZ oscillator ticks, counted from the hold release that loaded the counters. The release restarts the divider and the trim accumulator.
- R3: Seconds and minutes roll 59 to 00, hours roll 23 to 00, and the date rolls past the month's last day (30 for months 04, 06, 09 and 11, otherwise 31) to 01. Month 12 rolls to 01, all in BCD.
- R4: February has 29 days when the year value is divisible by 4, otherwise 28.
- R5: A year rollover from 99 to 00 sets the century flag (register 0 bit 6, read-only). A read of register 0 clears it.
- R6: The weekday (register 8, bits 2:0) counts 1 to 7 and back to 1, stepping once at each midnight and independent of the date.
- R7: Register map: address 2 seconds, 3 minutes, 4 hours, 5 date, 6 month, 7 year, 8 weekday. Register 0 holds bit 0 snapshot, bit 1 hold and bit 2 calibration mode. A 0-to-1 write of the snapshot bit copies the counters into the bank, including a second update that is pending in that cycle. No further copy happens until the bit is written back to 0.
- R8: While hold is 1 the counters do not advance. Writes to addresses 2 to 8 fill the bank. Writing hold from 1 to 0 loads the bank into the counters.
- R9: Register 1 bit 7 = 1 stops the divider, the calendar and the 512 Hz divider.
- R10: With calibration mode 1, `cal_out` toggles every TICK_HZ/1024 oscillator ticks whatever the trim is. With calibration mode 0 it is held 0.
- R11: Register 1 bits 4:0 (trim magnitude) change only on a write while calibration mode is 1. Bit 5 (trim sign) and bit 7 accept writes at any time.
- R12: Trim magnitude N adds N to an accumulator on every running tick. Each time the sum reaches TRIM_WINDOW, the window is subtracted and a correction applies to that tick: sign 1 counts it twice, sign 0 drops it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One-cycle enable per oscillator tick |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears century flag on address 0) |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| cal_out | output | 1 | 512 Hz calibration square wave |

## Verification
The hardest case to reach is a snapshot edge that falls in the same cycle as a pending one-second update, since the update must land in the copy. Because a hold release restarts the divider and the trim accumulator, the bench knows the exact cycle of every second boundary. It places snapshot writes one cycle before and exactly on that boundary, with and without trim. Rollover corners are reached by loading times one second before midnight through the hold path.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic [7:0] date;
        logic [7:0] month;
        logic [7:0] year;
        logic [2:0] dow;
    } rtc_time_t;

    localparam rtc_time_t TIME_RESET = '{sec: 8'h00, min: 8'h00, hour: 8'h00,
                                         date: 8'h01, month: 8'h01, year: 8'h00,
                                         dow: 3'd1};

    localparam logic [3:0] ADR_CTL   = 4'd0;
    localparam logic [3:0] ADR_TRIM  = 4'd1;
    localparam logic [3:0] ADR_SEC   = 4'd2;
    localparam logic [3:0] ADR_MIN   = 4'd3;
    localparam logic [3:0] ADR_HOUR  = 4'd4;
    localparam logic [3:0] ADR_DATE  = 4'd5;
    localparam logic [3:0] ADR_MONTH = 4'd6;
    localparam logic [3:0] ADR_YEAR  = 4'd7;
    localparam logic [3:0] ADR_DOW   = 4'd8;

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        else                return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic [7:0] month_last(input logic [7:0] mon, input logic [7:0] yr);
        logic [6:0] y;
        y = 7'(yr[7:4]) * 7'd10 + 7'(yr[3:0]);
        case (mon)
            8'h02:                      return (y[1:0] == 2'd0) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_timebase.sv
module rtc_timebase #(
    parameter int TICK_HZ = 32768,
    parameter int WINDOW  = 230400
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       osc_tick,
    input  logic       stop,
    input  logic       hold,
    input  logic       restart,
    input  logic       trim_sign,
    input  logic [4:0] trim_mag,
    input  logic       cal_en,
    output logic       sec_pend,
    output logic       cal_out
);
    localparam int PW   = $clog2(TICK_HZ + 2);
    localparam int AW   = $clog2(WINDOW + 32);
    localparam int HALF = (TICK_HZ / 1024 < 1) ? 1 : TICK_HZ / 1024;
    localparam int CW   = $clog2(HALF + 1);

    logic [PW-1:0] pre_q, psum, pre_nx;
    logic [AW-1:0] acc_q, asum, acc_nx;
    logic [CW-1:0] ccnt_q;
    logic [1:0]    step;
    logic          corr, wrap, run;

    assign run = osc_tick && !stop && !hold;

    always_comb begin
        asum   = acc_q + AW'(trim_mag);
        corr   = (asum >= AW'(WINDOW));
        acc_nx = corr ? asum - AW'(WINDOW) : asum;
        step   = corr ? (trim_sign ? 2'd2 : 2'd0) : 2'd1;
        psum   = pre_q + PW'(step);
        wrap   = (psum >= PW'(TICK_HZ));
        pre_nx = wrap ? psum - PW'(TICK_HZ) : psum;
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pre_q    <= '0;
            acc_q    <= '0;
            sec_pend <= 1'b0;
        end else begin
            sec_pend <= run && wrap;
            if (run) begin
                pre_q <= pre_nx;
                acc_q <= acc_nx;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !cal_en) begin
            ccnt_q  <= '0;
            cal_out <= 1'b0;
        end else if (osc_tick && !stop) begin
            if (ccnt_q == CW'(HALF - 1)) begin
                ccnt_q  <= '0;
                cal_out <= ~cal_out;
            end else begin
                ccnt_q <= ccnt_q + CW'(1);
            end
        end
    end

    // R10: calibration output low once the mode is off
    a_r10_cal_low: assert property (@(posedge clk) disable iff (rst)
        !cal_en |=> !cal_out);
    // R9: a stopped oscillator freezes the divider
    a_r9_stop_freeze: assert property (@(posedge clk) disable iff (rst)
        (stop && !restart) |=> $stable(pre_q));
    // R2: a second pulse lasts one cycle
    a_r2_pend_single: assert property (@(posedge clk) disable iff (rst)
        sec_pend |=> !sec_pend);

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_cal_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      adv,
    input  logic      load,
    input  rtc_time_t load_val,
    output rtc_time_t cur,
    output rtc_time_t nxt,
    output logic      year_wrap
);
    always_comb begin
        nxt       = cur;
        year_wrap = 1'b0;
        if (adv) begin
            if (cur.sec != 8'h59) nxt.sec = bcd_inc(cur.sec);
            else begin
                nxt.sec = 8'h00;
                if (cur.min != 8'h59) nxt.min = bcd_inc(cur.min);
                else begin
                    nxt.min = 8'h00;
                    if (cur.hour != 8'h23) nxt.hour = bcd_inc(cur.hour);
                    else begin
                        nxt.hour = 8'h00;
                        nxt.dow  = (cur.dow == 3'd7) ? 3'd1 : cur.dow + 3'd1;
                        if (cur.date != month_last(cur.month, cur.year))
                            nxt.date = bcd_inc(cur.date);
                        else begin
                            nxt.date = 8'h01;
                            if (cur.month != 8'h12) nxt.month = bcd_inc(cur.month);
                            else begin
                                nxt.month = 8'h01;
                                if (cur.year != 8'h99) nxt.year = bcd_inc(cur.year);
                                else begin
                                    nxt.year  = 8'h00;
                                    year_wrap = 1'b1;
                                end
                            end
                        end
                    end
                end
            end
        end
        if (load) begin
            nxt       = load_val;
            year_wrap = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= TIME_RESET;
        else     cur <= nxt;
    end

    // R8: no update without a tick or a load
    a_r8_still: assert property (@(posedge clk) disable iff (rst)
        (!adv && !load) |=> $stable(cur));
    // R3: seconds wrap to zero
    a_r3_sec_wrap: assert property (@(posedge clk) disable iff (rst)
        (adv && !load && cur.sec == 8'h59) |=> (cur.sec == 8'h00));
    // R6: weekday ring closes at midnight
    a_r6_dow_ring: assert property (@(posedge clk) disable iff (rst)
        (adv && !load && cur.hour == 8'h23 && cur.min == 8'h59 &&
         cur.sec == 8'h59 && cur.dow == 3'd7) |=> (cur.dow == 3'd1));

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
    import rtc_cal_pkg::*;
#(
    parameter int TICK_HZ     = 32768,
    parameter int TRIM_WINDOW = 230400
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       osc_tick,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [3:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       cal_out
);
    logic       ctl_snap, ctl_hold, ctl_cal, cent_flag;
    logic       trim_stop, trim_sign;
    logic [4:0] trim_mag;
    rtc_time_t  bank, cur, nxt;
    logic       year_wrap, sec_pend, adv;
    logic       wr_ctl, snap_edge, release_hold;

    assign wr_ctl       = reg_wr && (reg_addr == ADR_CTL);
    assign snap_edge    = wr_ctl && reg_wdata[0] && !ctl_snap;
    assign release_hold = wr_ctl && !reg_wdata[1] && ctl_hold;
    assign adv          = sec_pend && !ctl_hold;

    rtc_timebase #(.TICK_HZ(TICK_HZ), .WINDOW(TRIM_WINDOW)) u_timebase (
        .clk       (clk),
        .rst       (rst),
        .osc_tick  (osc_tick),
        .stop      (trim_stop),
        .hold      (ctl_hold),
        .restart   (release_hold),
        .trim_sign (trim_sign),
        .trim_mag  (trim_mag),
        .cal_en    (ctl_cal),
        .sec_pend  (sec_pend),
        .cal_out   (cal_out)
    );

    rtc_calendar u_calendar (
        .clk       (clk),
        .rst       (rst),
        .adv       (adv),
        .load      (release_hold),
        .load_val  (bank),
        .cur       (cur),
        .nxt       (nxt),
        .year_wrap (year_wrap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_snap  <= 1'b0;
            ctl_hold  <= 1'b0;
            ctl_cal   <= 1'b0;
            trim_stop <= 1'b0;
            trim_sign <= 1'b0;
            trim_mag  <= '0;
        end else begin
            if (wr_ctl) begin
                ctl_snap <= reg_wdata[0];
                ctl_hold <= reg_wdata[1];
                ctl_cal  <= reg_wdata[2];
            end
            if (reg_wr && reg_addr == ADR_TRIM) begin
                trim_stop <= reg_wdata[7];
                trim_sign <= reg_wdata[5];
                if (ctl_cal) trim_mag <= reg_wdata[4:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                                  cent_flag <= 1'b0;
        else if (year_wrap)                       cent_flag <= 1'b1;
        else if (reg_rd && reg_addr == ADR_CTL)   cent_flag <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bank <= TIME_RESET;
        end else if (snap_edge) begin
            bank <= nxt;
        end else if (reg_wr) begin
            case (reg_addr)
                ADR_SEC:   bank.sec   <= reg_wdata;
                ADR_MIN:   bank.min   <= reg_wdata;
                ADR_HOUR:  bank.hour  <= reg_wdata;
                ADR_DATE:  bank.date  <= reg_wdata;
                ADR_MONTH: bank.month <= reg_wdata;
                ADR_YEAR:  bank.year  <= reg_wdata;
                ADR_DOW:   bank.dow   <= reg_wdata[2:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (reg_addr)
            ADR_CTL:   reg_rdata = {1'b0, cent_flag, 3'b000, ctl_cal, ctl_hold, ctl_snap};
            ADR_TRIM:  reg_rdata = {trim_stop, 1'b0, trim_sign, trim_mag};
            ADR_SEC:   reg_rdata = bank.sec;
            ADR_MIN:   reg_rdata = bank.min;
            ADR_HOUR:  reg_rdata = bank.hour;
            ADR_DATE:  reg_rdata = bank.date;
            ADR_MONTH: reg_rdata = bank.month;
            ADR_YEAR:  reg_rdata = bank.year;
            ADR_DOW:   reg_rdata = {5'b00000, bank.dow};
            default:   reg_rdata = 8'h00;
        endcase
    end

    // R5: century flag follows a year wrap
    a_r5_century_set: assert property (@(posedge clk) disable iff (rst)
        year_wrap |=> cent_flag);
    // R7: bank only changes through field writes while snapshot stays high
    a_r7_no_resnap: assert property (@(posedge clk) disable iff (rst)
        (ctl_snap && !(reg_wr && reg_addr != ADR_CTL && reg_addr != ADR_TRIM))
        |=> $stable(bank));
    // R11: trim magnitude locked outside calibration mode
    a_r11_mag_locked: assert property (@(posedge clk) disable iff (rst)
        !ctl_cal |=> $stable(trim_mag));
    // R8: hold release loads the bank into the counters
    a_r8_load: assert property (@(posedge clk) disable iff (rst)
        release_hold |=> (cur == $past(bank)));

endmodule

// File: tb/test_rtc_calendar_core.sv
module test_rtc_calendar_core;
    localparam int HZ  = 2048;
    localparam int WIN = 640;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       osc_tick = 1'b1;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [3:0] reg_addr = 4'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       cal_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    rtc_calendar_core #(.TICK_HZ(HZ), .TRIM_WINDOW(WIN)) i_rtc_calendar_core (
        .clk(clk), .rst(rst), .osc_tick(osc_tick), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cal_out(cal_out)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // starts and ends at a negedge; the write lands on the next posedge
    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [3:0] a, input logic [7:0] exp);
        logic [7:0] d;
        rd(a, d);
        check(tag, d, exp);
    endtask

    // hold, fill the bank, release: the release edge is E0
    task automatic load_time(input logic [7:0] s, mi, h, dt, mo, y, input logic [7:0] dw);
        wr(4'd0, 8'h02);
        wr(4'd2, s); wr(4'd3, mi); wr(4'd4, h);
        wr(4'd5, dt); wr(4'd6, mo); wr(4'd7, y); wr(4'd8, dw);
        wr(4'd0, 8'h00);
    endtask

    // snapshot edge placed at E_m after the release
    task automatic snap_at(input int m);
        repeat (m - 1) @(negedge clk);
        wr(4'd0, 8'h01);
        wr(4'd0, 8'h00);
    endtask

    function automatic int ticks_to_sec(input bit sgn, input int n);
        int cnt = 0;
        int acc = 0;
        for (int k = 1; k < 100000; k++) begin
            int stp = 1;
            acc += n;
            if (acc >= WIN) begin
                acc -= WIN;
                stp = sgn ? 2 : 0;
            end
            cnt += stp;
            if (cnt >= HZ) return k;
        end
        return -1;
    endfunction

    task automatic t_reset;
        check("R1 cal_out", {7'd0, cal_out}, 8'h00);
        rd_chk("R1 ctl", 4'd0, 8'h00);
        rd_chk("R1 trim", 4'd1, 8'h00);
        rd_chk("R1 sec", 4'd2, 8'h00);
        rd_chk("R1 min", 4'd3, 8'h00);
        rd_chk("R1 hour", 4'd4, 8'h00);
        rd_chk("R1 date", 4'd5, 8'h01);
        rd_chk("R1 month", 4'd6, 8'h01);
        rd_chk("R1 year", 4'd7, 8'h00);
        rd_chk("R1 dow", 4'd8, 8'h01);
    endtask

    task automatic t_second;
        load_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h01);
        snap_at(HZ);
        rd_chk("R2 before boundary", 4'd2, 8'h00);
        load_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h01);
        snap_at(HZ + 1);
        rd_chk("R7 pending update in snapshot", 4'd2, 8'h01);
    endtask

    task automatic t_roll;
        load_time(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99, 8'h07);
        snap_at(HZ + 1);
        rd_chk("R3 sec wrap", 4'd2, 8'h00);
        rd_chk("R3 min wrap", 4'd3, 8'h00);
        rd_chk("R3 hour wrap", 4'd4, 8'h00);
        rd_chk("R3 date wrap", 4'd5, 8'h01);
        rd_chk("R3 month wrap", 4'd6, 8'h01);
        rd_chk("R5 year wrap", 4'd7, 8'h00);
        rd_chk("R6 dow 7 to 1", 4'd8, 8'h01);
        rd_chk("R5 century set", 4'd0, 8'h40);
        rd_chk("R5 century cleared by read", 4'd0, 8'h00);
        load_time(8'h59, 8'h59, 8'h23, 8'h30, 8'h04, 8'h05, 8'h03);
        snap_at(HZ + 1);
        rd_chk("R3 30-day month date", 4'd5, 8'h01);
        rd_chk("R3 30-day month month", 4'd6, 8'h05);
        rd_chk("R6 dow step", 4'd8, 8'h04);
        load_time(8'h59, 8'h59, 8'h23, 8'h30, 8'h05, 8'h05, 8'h03);
        snap_at(HZ + 1);
        rd_chk("R3 31-day month date", 4'd5, 8'h31);
    endtask

    task automatic t_leap;
        load_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h24, 8'h01);
        snap_at(HZ + 1);
        rd_chk("R4 leap 28 to 29", 4'd5, 8'h29);
        load_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h23, 8'h01);
        snap_at(HZ + 1);
        rd_chk("R4 common year date", 4'd5, 8'h01);
        rd_chk("R4 common year month", 4'd6, 8'h03);
        load_time(8'h59, 8'h59, 8'h23, 8'h29, 8'h02, 8'h24, 8'h01);
        snap_at(HZ + 1);
        rd_chk("R4 leap 29 to 01", 4'd5, 8'h01);
        rd_chk("R4 leap month", 4'd6, 8'h03);
    endtask

    task automatic t_snap_hold;
        load_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h01);
        repeat (9) @(negedge clk);
        wr(4'd0, 8'h01);
        repeat (3000) @(negedge clk);
        wr(4'd0, 8'h01);
        rd_chk("R7 no copy while bit stays 1", 4'd2, 8'h00);
        wr(4'd0, 8'h00);
        wr(4'd0, 8'h01);
        rd_chk("R7 new copy after 0 then 1", 4'd2, 8'h01);
        wr(4'd0, 8'h00);
    endtask

    task automatic t_freeze;
        load_time(8'h30, 8'h20, 8'h10, 8'h05, 8'h06, 8'h07, 8'h02);
        wr(4'd0, 8'h02);
        repeat (5000) @(negedge clk);
        wr(4'd0, 8'h03);
        rd_chk("R8 frozen seconds", 4'd2, 8'h30);
        rd_chk("R8 frozen minutes", 4'd3, 8'h20);
        wr(4'd0, 8'h02);
        wr(4'd2, 8'h45);
        wr(4'd0, 8'h00);
        wr(4'd0, 8'h01);
        wr(4'd0, 8'h00);
        rd_chk("R8 loaded seconds", 4'd2, 8'h45);
        rd_chk("R8 kept minutes", 4'd3, 8'h20);
    endtask

    task automatic t_stop;
        int tog = 0;
        logic prev;
        wr(4'd1, 8'h80);
        load_time(8'h07, 8'h06, 8'h05, 8'h01, 8'h01, 8'h00, 8'h01);
        repeat (5000) @(negedge clk);
        wr(4'd0, 8'h01);
        wr(4'd0, 8'h00);
        rd_chk("R9 stopped seconds", 4'd2, 8'h07);
        rd_chk("R9 stopped hours", 4'd4, 8'h05);
        wr(4'd0, 8'h04);
        prev = cal_out;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (cal_out !== prev) tog++;
            prev = cal_out;
        end
        check("R9 no cal toggles when stopped", 8'(tog), 8'd0);
        wr(4'd0, 8'h00);
        wr(4'd1, 8'h00);
    endtask

    task automatic count_cal(input string tag);
        int tog = 0;
        logic prev;
        repeat (4) @(negedge clk);
        prev = cal_out;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (cal_out !== prev) tog++;
            prev = cal_out;
        end
        check(tag, 8'(tog), 8'd20);
    endtask

    task automatic t_cal;
        int hi = 0;
        wr(4'd0, 8'h04);
        count_cal("R10 toggle rate");
        wr(4'd1, 8'h3F);
        rd_chk("R11 magnitude written in cal mode", 4'd1, 8'h3F);
        count_cal("R10 rate unaffected by trim");
        wr(4'd0, 8'h00);
        repeat (2) @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (cal_out) hi++;
        end
        check("R10 low when mode off", 8'(hi), 8'd0);
        wr(4'd1, 8'h00);
        rd_chk("R11 magnitude locked, sign written", 4'd1, 8'h1F);
    endtask

    task automatic set_trim(input bit sgn, input logic [4:0] n);
        wr(4'd0, 8'h04);
        wr(4'd1, {2'b00, sgn, n});
        wr(4'd0, 8'h00);
    endtask

    task automatic trim_case(input bit sgn, input logic [4:0] n, input string tag);
        int p = ticks_to_sec(sgn, int'(n));
        set_trim(sgn, n);
        load_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h01);
        snap_at(p);
        rd_chk({tag, " before"}, 4'd2, 8'h00);
        load_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h01);
        snap_at(p + 1);
        rd_chk({tag, " at"}, 4'd2, 8'h01);
    endtask

    task automatic t_trim;
        trim_case(1'b1, 5'd31, "R12 add 31");
        trim_case(1'b0, 5'd31, "R12 drop 31");
        trim_case(1'b1, 5'd5,  "R12 add 5");
        set_trim(1'b0, 5'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_second();
        t_roll();
        t_leap();
        t_snap_hold();
        t_freeze();
        t_stop();
        t_cal();
        t_trim();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule